// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the housekeeping strobes of an asynchronous DRAM so that the host read/write controller never has to. After reset it holds off for a programmable power-on pause and then runs a fixed number of strobe cycles that each contain a RAS pulse. Only after that does it report the memory as ready. From then on it schedules periodic refresh cycles at a rate that meets the memory's refresh budget. It keeps up to a bounded number of them pending while the bus is busy.

Every strobe cycle is bought from a bus arbiter with a request/grant handshake. The default cycle is a CAS-first refresh: CAS drops a set number of cycles before RAS, no address is driven, and the memory's own row counter picks the row. A mode input selects a RAS-only variant instead. In that variant an internal row counter is put on the address pins and CAS stays high. If the block goes too long without finishing a cycle, it treats the memory as unrefreshed. It then drops its ready flag and repeats the pause and the initialization cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: During and after reset, rasN and casN are high and busReq, addrOe, refDone and initDone are low. busReq first rises PAUSE_CYC+1 clock cycles after reset is released.
- R2: Exactly INIT_CYC strobe cycles, each with one falling edge of rasN, are completed before initDone rises. initDone rises in the same cycle as the refDone pulse of the last of them.
- R3: Once ready, one refresh becomes due every REF_PER cycles. Due refreshes pile up to at most MAX_PEND and the excess is dropped. Each completed refresh removes one, and the block keeps busReq up while any remain.
- R4: In a CAS-first cycle, casN is low for exactly T_CSR cycles before rasN falls. It stays low for exactly T_CHR cycles after rasN falls, then returns high while rasN is still low.
- R5: addrOe is low whenever casN is low, so a CAS-first cycle never drives the address pins.
- R6: rasN stays low for exactly T_RAS cycles per strobe cycle. It is followed by T_RP cycles with rasN and casN high, still under busReq.
- R7: A strobe cycle starts only in the cycle after busGnt is sampled high while busReq is up. busReq stays high until the precharge ends. rasN, casN and addrOe are never active while busReq is low.
- R8: refDone is a one-cycle pulse in the cycle after the precharge of every completed strobe cycle, whether it is an initialization cycle or a refresh.
- R9: If no strobe cycle completes for STALE_LIM cycles while ready and between cycles, initDone drops and busReq drops. The power-on pause and INIT_CYC initialization cycles are then repeated before initDone rises again.
- R10: When rasOnlyMode is high at the cycle in which the grant is taken, that strobe cycle keeps casN high. It drives addrOe high with addrOut equal to an internal row counter during the lead and RAS-low phases. The counter starts at 0 after reset, steps by one after each such cycle, and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasOnlyMode | input | 1 | 1 selects RAS-only refresh with driven row address |
| busGnt | input | 1 | Arbiter grant |
| busReq | output | 1 | Request for the memory bus |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| addrOut | output | ROW_W | Row address for RAS-only cycles |
| addrOe | output | 1 | Address pins driven |
| refDone | output | 1 | One-cycle pulse per completed strobe cycle |
| initDone | output | 1 | Memory initialized and ready |

## Verification
The strobes follow the state directly. A grant sampled on one edge moves casN (CAS-first) or addrOe (RAS-only) after that same edge. rasN falls T_CSR cycles later, and refDone and initDone change one edge after the last precharge cycle. busReq first rises on edge PAUSE_CYC+1 after reset release. The bench drives inputs on the falling edge and steps its behavioural model on the rising edge with the same sampled inputs. It compares every output in the middle of each cycle, so each result is checked in exactly the cycle it is due. Phase lengths, the saturated burst of eight back-to-back refreshes, the row sequence through its wrap, and the stale re-initialization are also counted directly at the ports.

// File: rtl/dram_refseq_pkg.sv
package dram_refseq_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_WAIT,
    ST_LEAD,
    ST_ACT,
    ST_PRE
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic pauseRun;
    logic cycleDone;
    logic reinit;
    logic rowStep;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic pauseDone;
    logic needCycle;
    logic staleHit;
  } seqStatus_t;

endpackage

// File: rtl/refseq_datapath.sv
module refseq_datapath
  import dram_refseq_pkg::*;
#(
  parameter int ROW_W     = 8,
  parameter int PAUSE_CYC = 40000,
  parameter int INIT_CYC  = 8,
  parameter int REF_PER   = 6250,
  parameter int MAX_PEND  = 8,
  parameter int STALE_LIM = 1600000
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  output seqStatus_t       stat,
  output logic [ROW_W-1:0] rowAddr,
  output logic             doneQ,
  output logic             readyQ
);
  localparam int PA_W = $clog2(PAUSE_CYC + 1);
  localparam int TK_W = $clog2(REF_PER + 1);
  localparam int PN_W = $clog2(MAX_PEND + 1);
  localparam int IN_W = $clog2(INIT_CYC + 1);
  localparam int SL_W = $clog2(STALE_LIM + 1);

  logic [PA_W-1:0] pauseCnt;
  logic [TK_W-1:0] tickCnt;
  logic [PN_W-1:0] pendCnt;
  logic [IN_W-1:0] initCnt;
  logic [SL_W-1:0] staleCnt;
  logic [PN_W:0]   pendSum;
  logic            tickHit;
  logic            consume;

  assign tickHit = readyQ && (tickCnt == TK_W'(REF_PER - 1));
  assign consume = strb.cycleDone && readyQ;

  assign stat.pauseDone = (pauseCnt == PA_W'(PAUSE_CYC - 1));
  assign stat.needCycle = !readyQ || (pendCnt != '0);
  assign stat.staleHit  = readyQ && (staleCnt == SL_W'(STALE_LIM));

  always_comb begin
    pendSum = {1'b0, pendCnt};
    if (tickHit && !consume)      pendSum = pendSum + (PN_W+1)'(1);
    else if (!tickHit && consume) pendSum = pendSum - (PN_W+1)'(1);
    if (pendSum > (PN_W+1)'(MAX_PEND)) pendSum = (PN_W+1)'(MAX_PEND);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pauseCnt <= '0;
      tickCnt  <= '0;
      pendCnt  <= '0;
      initCnt  <= '0;
      staleCnt <= '0;
      rowAddr  <= '0;
      doneQ    <= 1'b0;
      readyQ   <= 1'b0;
    end else begin
      pauseCnt <= (strb.pauseRun && !stat.pauseDone) ? pauseCnt + PA_W'(1) : '0;
      doneQ    <= strb.cycleDone;
      if (strb.rowStep) rowAddr <= rowAddr + ROW_W'(1);
      if (strb.reinit) begin
        readyQ   <= 1'b0;
        initCnt  <= '0;
        pendCnt  <= '0;
        tickCnt  <= '0;
        staleCnt <= '0;
      end else begin
        pendCnt  <= pendSum[PN_W-1:0];
        tickCnt  <= readyQ ? (tickHit ? '0 : tickCnt + TK_W'(1)) : '0;
        staleCnt <= (!readyQ || strb.cycleDone) ? '0 :
                    (stat.staleHit ? staleCnt : staleCnt + SL_W'(1));
        if (strb.cycleDone && !readyQ) begin
          initCnt <= initCnt + IN_W'(1);
          if (initCnt == IN_W'(INIT_CYC - 1)) readyQ <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/refseq_ctrl.sv
module refseq_ctrl
  import dram_refseq_pkg::*;
#(
  parameter int T_CSR       = 2,
  parameter int T_RAS       = 8,
  parameter int T_CHR       = 2,
  parameter int T_RP        = 6,
  parameter int ROW_MODE_EN = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busGnt,
  input  logic       rasOnlyMode,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output logic       busReq,
  output logic       rasN,
  output logic       casN,
  output logic       addrOe
);
  localparam int PH_MAX = (T_RAS > T_RP) ? ((T_RAS > T_CSR) ? T_RAS : T_CSR)
                                         : ((T_RP > T_CSR) ? T_RP : T_CSR);
  localparam int PH_W = $clog2(PH_MAX + 1);

  seqState_t       state, stateNext;
  logic [PH_W-1:0] phase;
  logic            modeQ;
  logic            leadEnd, actEnd, preEnd, inStrobe, reinit;

  assign leadEnd  = (state == ST_LEAD) && (phase == PH_W'(T_CSR - 1));
  assign actEnd   = (state == ST_ACT)  && (phase == PH_W'(T_RAS - 1));
  assign preEnd   = (state == ST_PRE)  && (phase == PH_W'(T_RP - 1));
  assign inStrobe = (state == ST_LEAD) || (state == ST_ACT) || (state == ST_PRE);
  assign reinit   = ((state == ST_IDLE) || (state == ST_WAIT)) && stat.staleHit;

  assign strb.pauseRun  = (state == ST_PAUSE);
  assign strb.cycleDone = preEnd;
  assign strb.reinit    = reinit;
  assign strb.rowStep   = preEnd && modeQ;

  always_comb begin
    stateNext = state;
    case (state)
      ST_PAUSE: if (stat.pauseDone) stateNext = ST_IDLE;
      ST_IDLE: begin
        if (reinit)              stateNext = ST_PAUSE;
        else if (stat.needCycle) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (reinit)      stateNext = ST_PAUSE;
        else if (busGnt) stateNext = ST_LEAD;
      end
      ST_LEAD: if (leadEnd) stateNext = ST_ACT;
      ST_ACT:  if (actEnd)  stateNext = ST_PRE;
      ST_PRE:  if (preEnd)  stateNext = ST_IDLE;
      default: stateNext = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_PAUSE;
      phase <= '0;
    end else begin
      state <= stateNext;
      phase <= (inStrobe && !(leadEnd || actEnd || preEnd)) ? phase + PH_W'(1) : '0;
    end
  end

  generate
    if (ROW_MODE_EN != 0) begin : g_rowMode
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) modeQ <= 1'b0;
        else if ((state == ST_WAIT) && busGnt && !reinit) modeQ <= rasOnlyMode;
      end
    end else begin : g_cbrOnly
      logic unusedMode;
      assign unusedMode = rasOnlyMode;
      assign modeQ = 1'b0;
    end
  endgenerate

  assign busReq = (state == ST_WAIT) || inStrobe;
  assign rasN   = (state != ST_ACT);
  assign casN   = !(!modeQ && ((state == ST_LEAD) ||
                               ((state == ST_ACT) && (phase < PH_W'(T_CHR)))));
  assign addrOe = modeQ && ((state == ST_LEAD) || (state == ST_ACT));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refseq_pkg::*;
#(
  parameter int ROW_W       = 8,
  parameter int PAUSE_CYC   = 40000,
  parameter int INIT_CYC    = 8,
  parameter int REF_PER     = 6250,
  parameter int MAX_PEND    = 8,
  parameter int STALE_LIM   = 1600000,
  parameter int T_CSR       = 2,
  parameter int T_RAS       = 8,
  parameter int T_CHR       = 2,
  parameter int T_RP        = 6,
  parameter int ROW_MODE_EN = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rasOnlyMode,
  input  logic             busGnt,
  output logic             busReq,
  output logic             rasN,
  output logic             casN,
  output logic [ROW_W-1:0] addrOut,
  output logic             addrOe,
  output logic             refDone,
  output logic             initDone
);
  seqStrobe_t strb;
  seqStatus_t stat;

  refseq_ctrl #(
    .T_CSR(T_CSR), .T_RAS(T_RAS), .T_CHR(T_CHR), .T_RP(T_RP),
    .ROW_MODE_EN(ROW_MODE_EN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busGnt(busGnt), .rasOnlyMode(rasOnlyMode),
    .stat(stat), .strb(strb), .busReq(busReq), .rasN(rasN), .casN(casN),
    .addrOe(addrOe)
  );

  refseq_datapath #(
    .ROW_W(ROW_W), .PAUSE_CYC(PAUSE_CYC), .INIT_CYC(INIT_CYC),
    .REF_PER(REF_PER), .MAX_PEND(MAX_PEND), .STALE_LIM(STALE_LIM)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat), .rowAddr(addrOut),
    .doneQ(refDone), .readyQ(initDone)
  );

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int T_RAS = 8,
  parameter int T_RP  = 6
) (
  input logic clk,
  input logic rstN,
  input logic rasN,
  input logic casN,
  input logic addrOe,
  input logic busReq,
  input logic refDone
);
  localparam int CMAX = T_RAS + T_RP + 2;
  localparam int CW   = $clog2(CMAX + 1);

  logic [CW-1:0] lowCnt, highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= '0;
    end else begin
      lowCnt  <= !rasN ? ((lowCnt == CW'(CMAX)) ? lowCnt : lowCnt + CW'(1)) : '0;
      highCnt <= rasN ? ((highCnt == CW'(CMAX)) ? highCnt : highCnt + CW'(1)) : '0;
    end
  end

  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && !addrOe) |-> (!casN && $past(!casN))); // R4
  AST_NO_ADDR_WITH_CAS: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !addrOe); // R5
  AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (lowCnt >= CW'(T_RAS))); // R6
  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && (highCnt != CW'(CMAX))) |-> (highCnt >= CW'(T_RP))); // R6
  AST_STROBE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !casN || addrOe) |-> busReq); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    refDone |=> !refDone); // R8

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.T_RAS(T_RAS), .T_RP(T_RP)) u_chk (
  .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .addrOe(addrOe),
  .busReq(busReq), .refDone(refDone)
);

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb;
  localparam int ROW_W = 8, PAUSE_CYC = 20, INIT_CYC = 8, REF_PER = 40,
                 MAX_PEND = 8, STALE_LIM = 600, T_CSR = 2, T_RAS = 6,
                 T_CHR = 2, T_RP = 5;
  localparam int M_PAUSE = 0, M_IDLE = 1, M_WAIT = 2, M_LEAD = 3, M_ACT = 4, M_PRE = 5;

  logic clk = 1'b0, rstN = 1'b0, rasOnlyMode = 1'b0, busGnt = 1'b0;
  logic busReq, rasN, casN, addrOe, refDone, initDone;
  logic [ROW_W-1:0] addrOut;
  int total = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .ROW_W(ROW_W), .PAUSE_CYC(PAUSE_CYC), .INIT_CYC(INIT_CYC), .REF_PER(REF_PER),
    .MAX_PEND(MAX_PEND), .STALE_LIM(STALE_LIM), .T_CSR(T_CSR), .T_RAS(T_RAS),
    .T_CHR(T_CHR), .T_RP(T_RP), .ROW_MODE_EN(1)
  ) u_dut (
    .clk(clk), .rstN(rstN), .rasOnlyMode(rasOnlyMode), .busGnt(busGnt),
    .busReq(busReq), .rasN(rasN), .casN(casN), .addrOut(addrOut),
    .addrOe(addrOe), .refDone(refDone), .initDone(initDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // behavioural reference model
  int mSt, mPh, mPause, mInit, mPend, mTick, mStale, mRow;
  bit mMode, mDone, mReady;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = M_PAUSE; mPh = 0; mPause = 0; mInit = 0; mPend = 0;
      mTick = 0; mStale = 0; mRow = 0; mMode = 0; mDone = 0; mReady = 0;
    end else begin
      bit cyc, hit, re, tk, need, pd;
      cyc  = (mSt == M_PRE) && (mPh == T_RP - 1);
      hit  = mReady && (mStale == STALE_LIM);
      re   = ((mSt == M_IDLE) || (mSt == M_WAIT)) && hit;
      tk   = mReady && (mTick == REF_PER - 1);
      need = !mReady || (mPend != 0);
      pd   = (mPause == PAUSE_CYC - 1);
      mPause = ((mSt == M_PAUSE) && !pd) ? mPause + 1 : 0;
      mDone  = cyc;
      if (cyc && mMode) mRow = (mRow + 1) % 256;
      if (re) begin
        mReady = 0; mInit = 0; mPend = 0; mTick = 0; mStale = 0;
      end else begin
        if (tk) mPend++;
        if (cyc && mReady) mPend--;
        if (mPend > MAX_PEND) mPend = MAX_PEND;
        mTick  = mReady ? (tk ? 0 : mTick + 1) : 0;
        mStale = (!mReady || cyc) ? 0 : (hit ? mStale : mStale + 1);
        if (cyc && !mReady) begin
          mInit++;
          if (mInit == INIT_CYC) mReady = 1;
        end
      end
      case (mSt)
        M_PAUSE: if (pd) mSt = M_IDLE;
        M_IDLE:  if (re) mSt = M_PAUSE; else if (need) mSt = M_WAIT;
        M_WAIT:  if (re) mSt = M_PAUSE;
                 else if (busGnt) begin mSt = M_LEAD; mPh = 0; mMode = rasOnlyMode; end
        M_LEAD:  if (mPh == T_CSR - 1) begin mSt = M_ACT; mPh = 0; end else mPh++;
        M_ACT:   if (mPh == T_RAS - 1) begin mSt = M_PRE; mPh = 0; end else mPh++;
        default: if (mPh == T_RP - 1) begin mSt = M_IDLE; mPh = 0; end else mPh++;
      endcase
    end
  end

  // every-cycle comparison plus watchdog
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "ALL", "watchdog cycles", cycles, 100000);
      summary();
    end
    if (rstN) begin
      bit eRas, eCas, eOe, eReq;
      eRas = (mSt != M_ACT);
      eCas = !(!mMode && ((mSt == M_LEAD) || ((mSt == M_ACT) && (mPh < T_CHR))));
      eOe  = mMode && ((mSt == M_LEAD) || (mSt == M_ACT));
      eReq = (mSt >= M_WAIT);
      check(rasN == eRas, "R6", "rasN", rasN, eRas);
      check(casN == eCas, "R4", "casN", casN, eCas);
      check(addrOe == eOe, "R5", "addrOe", addrOe, eOe);
      check(busReq == eReq, "R7", "busReq", busReq, eReq);
      check(refDone == mDone, "R8", "refDone", refDone, mDone);
      check(initDone == mReady, "R2", "initDone", initDone, mReady);
      if (eOe) check(int'(addrOut) == mRow, "R10", "addrOut", addrOut, mRow);
    end
  end

  task automatic measureCbr();
    int a = 0, b = 0, c = 0, d = 0, oe = 0;
    while (busReq) step();
    while (casN) step();
    while (!casN && rasN) begin a++; oe |= addrOe; step(); end
    while (!casN && !rasN) begin b++; oe |= addrOe; step(); end
    while (casN && !rasN) begin c++; step(); end
    while (rasN && busReq) begin d++; step(); end
    check(a == T_CSR, "R4", "cas lead cycles", a, T_CSR);
    check(b == T_CHR, "R4", "cas hold cycles", b, T_CHR);
    check(b + c == T_RAS, "R6", "ras low cycles", b + c, T_RAS);
    check(d == T_RP, "R6", "precharge cycles", d, T_RP);
    check(oe == 0, "R5", "addrOe in cas-first cycle", oe, 0);
  endtask

  initial begin
    int n, falls, pulses, expRow, wraps;
    bit prevRas, prevOe;
    repeat (3) step();
    check(rasN && casN && !busReq && !addrOe && !refDone && !initDone,
          "R1", "reset outputs", {rasN, casN, busReq, addrOe, refDone, initDone}, 6'b110000);
    rstN = 1'b1;
    busGnt = 1'b1;

    // R1: pause before first request
    n = 0;
    while (!busReq) begin step(); n++; end
    check(n == PAUSE_CYC + 1, "R1", "cycles to first busReq", n, PAUSE_CYC + 1);

    // R2: initialization cycles
    falls = 0; prevRas = rasN;
    while (!initDone) begin
      step();
      if (prevRas && !rasN) falls++;
      prevRas = rasN;
    end
    check(falls == INIT_CYC, "R2", "init ras pulses", falls, INIT_CYC);
    check(refDone == 1'b1, "R8", "refDone with initDone", refDone, 1);

    // R3: steady periodic refresh
    pulses = 0;
    repeat (400) begin step(); if (refDone) pulses++; end
    check(pulses >= 9 && pulses <= 11, "R3", "refreshes in 400 cycles", pulses, 10);

    measureCbr();

    // R3: saturation of pending refreshes
    busGnt = 1'b0;
    repeat (450) step();
    check(busReq == 1'b1, "R3", "busReq held while pending", busReq, 1);
    busGnt = 1'b1;
    pulses = 0;
    repeat (120) begin step(); if (refDone) pulses++; end
    check(pulses == MAX_PEND, "R3", "back-to-back burst", pulses, MAX_PEND);

    // R10: RAS-only mode with row sequence through wrap
    rasOnlyMode = 1'b1;
    expRow = 0; wraps = 0; prevOe = addrOe; n = 0;
    while (n < 260) begin
      step();
      if (addrOe) check(casN == 1'b1, "R10", "casN in ras-only", casN, 1);
      if (addrOe && !prevOe) begin
        check(int'(addrOut) == expRow, "R10", "row address", addrOut, expRow);
        if (expRow == 255) wraps++;
        expRow = (expRow + 1) % 256;
        n++;
      end
      prevOe = addrOe;
    end
    check(wraps == 1, "R10", "row wraps", wraps, 1);
    rasOnlyMode = 1'b0;
    measureCbr();

    // R9: stale memory triggers re-initialization
    busGnt = 1'b0;
    repeat (700) step();
    check(initDone == 1'b0, "R9", "initDone after stale gap", initDone, 0);
    busGnt = 1'b1;
    falls = 0; prevRas = rasN;
    while (!initDone) begin
      step();
      if (prevRas && !rasN) falls++;
      prevRas = rasN;
    end
    check(falls == INIT_CYC, "R9", "re-init ras pulses", falls, INIT_CYC);
    repeat (100) step();
    summary();
  end

endmodule